// File: doc/BRIEF.md
# Programmable SCL Clock Generator

This block produces the serial clock for a two-wire bus master from the system clock. A 3-bit rate code selects one of seven fixed system-clock divisors. The eighth code divides an external tick by eight. The output is open-drain: the block only ever pulls the line low (`scl_oe` = 1) or releases it. The line level is read back on `scl_i`, so the clock stretches when a slave holds the line and synchronizes with other masters on the wired-AND bus. Pulses come out only while `master_en` is asserted, which means the host is in a master transmit or master receive mode. In slave modes the generator is off.

The controller has four named states. `ST_OFF` releases the line and clears the phase counter. `ST_RELEASE` has the line released and waits until the synchronized bus level reads high. `ST_HIGH` has the line released and counts the rest of the high phase. `ST_LOW` pulls the line low for one full half period. The transitions are:
- OFF→RELEASE when the block is enabled.
- RELEASE→HIGH when the bus is seen high.
- HIGH→LOW when the count expires or when the bus is seen low (another master pulled it).
- LOW→RELEASE when the count expires.
- Any state→OFF when the enable drops.

The half period H for each code is: 0→128, 1→112, 2→96, 3→80, 4→480, 5→60, 6→4800 system clocks. These are the divisors 256, 224, 192, 160, 960, 120 and 9600, each halved. Code 7 uses 4 ticks per phase.

Top module: `scl_clock_gen`

## Requirements
- R1: While `rst_n` is low, `scl_oe` is 0, so the line is released.
- R2: For codes 0..6, each uncontended low phase (`scl_oe` = 1) lasts exactly H system clocks: 128, 112, 96, 80, 480, 60 or 4800 for codes 0, 1, 2, 3, 4, 5 and 6.
- R3: For codes 0..6 with no other driver, the line stays high for exactly H clocks between low phases, so the duty cycle is 50%.
- R4: With code 7, each phase ends on the 4th `tmr_tick` pulse after it starts. With a tick every 10 clocks, a low phase lasts 31..40 clocks and a high phase lasts 34..43 clocks, which includes the 3-clock read-back latency.
- R5: One clock after `master_en` is sampled low, `scl_oe` is 0, and it stays 0 while the block is disabled.
- R6: While another device holds the line low after the block has released it, `scl_oe` stays 0. Once the line rises, the high phase lasts exactly H clocks before the block pulls low again.
- R7: If the line goes low during the block's high phase, the block pulls low 3 clocks later (SYNC_STAGES+1) and holds the line low for a full H clocks, timed from that detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 while the host is in a master mode; 0 switches the generator off |
| rate_sel | input | 3 | Rate code: 0..6 fixed divisors, 7 external tick divided by eight |
| tmr_tick | input | 1 | One-clock pulse from an external timer overflow, used by code 7 |
| scl_i | input | 1 | Level of the bus clock line as read back |
| scl_oe | output | 1 | 1 pulls the clock line low; 0 releases it |

## Verification
Each fixed code is run on an uncontended bus. Measuring both the pull-low run and the released run separates a wrong divisor (R2) from lost read-back compensation (R3). The tick-driven code uses a tick spaced unlike any fixed divisor, so a design that counted system clocks would fall outside the accepted window. Two contention patterns are applied: a long hold after release, which tests stretching, and a short pull during the high phase, which tests restart of the low phase. They tell apart a generator that waits for the bus from one that free-runs. Dropping the enable mid-phase confirms the line is released at once.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_RELEASE,
        ST_HIGH,
        ST_LOW
    } scl_state_e;
endpackage

// File: rtl/scl_rate_decode.sv
// Maps the rate code to the counter reload values for each phase.
module scl_rate_decode #(
    parameter int CNT_W   = 13,
    parameter int DIV_0   = 256,
    parameter int DIV_1   = 224,
    parameter int DIV_2   = 192,
    parameter int DIV_3   = 160,
    parameter int DIV_4   = 960,
    parameter int DIV_5   = 120,
    parameter int DIV_6   = 9600,
    parameter int TMR_DIV = 8,
    parameter int LAT     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       rate_sel,
    output logic             use_tick,
    output logic [CNT_W-1:0] low_load,
    output logic [CNT_W-1:0] high_load
);
    localparam int TICK_HALF = TMR_DIV / 2;

    int half;

    always_comb begin
        use_tick = 1'b0;
        unique case (rate_sel)
            3'd0: half = DIV_0 / 2;
            3'd1: half = DIV_1 / 2;
            3'd2: half = DIV_2 / 2;
            3'd3: half = DIV_3 / 2;
            3'd4: half = DIV_4 / 2;
            3'd5: half = DIV_5 / 2;
            3'd6: half = DIV_6 / 2;
            default: begin
                half     = TICK_HALF;
                use_tick = 1'b1;
            end
        endcase
        low_load = CNT_W'(half - 1);
        // The read-back latency is already part of the released time in clock mode.
        if (use_tick) high_load = CNT_W'(half - 1);
        else          high_load = CNT_W'(half - LAT - 1);
    end

    // Clock mode needs room to subtract the read-back latency from the high phase (R2/R3).
    assert_half_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !use_tick |-> (half > LAT + 1));
endmodule

// File: rtl/scl_line_sync.sv
// Synchronizes the bus clock read-back into the system clock domain.
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_q
);
    generate
        if (STAGES == 1) begin : g_single
            logic pipe;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= 1'b1;
                else        pipe <= line_i;
            end
            assign line_q = pipe;
        end else begin : g_multi
            logic [STAGES-1:0] pipe;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], line_i};
            end
            assign line_q = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/scl_phase_timer.sv
// Down counter for one phase; it steps on every clock or only on enabled ticks.
module scl_phase_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (clear)              cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (step && cnt != '0)  cnt <= cnt - CNT_W'(1);
    end

    assign done = step && (cnt == '0);

    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !clear && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
    assert_cleared_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
endmodule

// File: rtl/scl_gen_fsm.sv
// Phase controller: pull low, release, wait for the bus to rise, then count the high phase.
module scl_gen_fsm
    import sclgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic scl_seen,
    input  logic phase_done,
    output logic scl_oe,
    output logic cnt_clear,
    output logic load_low,
    output logic load_high
);
    scl_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        load_low  = 1'b0;
        load_high = 1'b0;
        if (!master_en) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: state_nx = ST_RELEASE;
                ST_RELEASE: begin
                    if (scl_seen) begin
                        state_nx  = ST_HIGH;
                        load_high = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (!scl_seen || phase_done) begin
                        state_nx = ST_LOW;
                        load_low = 1'b1;
                    end
                end
                ST_LOW: begin
                    if (phase_done) state_nx = ST_RELEASE;
                end
                default: state_nx = ST_OFF;
            endcase
        end
    end

    always_comb begin
        scl_oe    = (state == ST_LOW);
        cnt_clear = (state == ST_OFF);
    end

    assert_off_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !scl_oe);
    assert_wait_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && state == ST_RELEASE && !scl_seen) |=> !scl_oe);
    assert_sync_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && state == ST_HIGH && !scl_seen) |=> scl_oe);
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 13,
    parameter int DIV_0       = 256,
    parameter int DIV_1       = 224,
    parameter int DIV_2       = 192,
    parameter int DIV_3       = 160,
    parameter int DIV_4       = 960,
    parameter int DIV_5       = 120,
    parameter int DIV_6       = 9600,
    parameter int TMR_DIV     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en,
    input  logic [2:0] rate_sel,
    input  logic       tmr_tick,
    input  logic       scl_i,
    output logic       scl_oe
);
    localparam int LAT = SYNC_STAGES + 1;

    logic             use_tick;
    logic [CNT_W-1:0] low_load, high_load, load_val;
    logic             scl_seen, phase_done, cnt_clear, load_low, load_high, step;

    scl_rate_decode #(
        .CNT_W(CNT_W), .DIV_0(DIV_0), .DIV_1(DIV_1), .DIV_2(DIV_2), .DIV_3(DIV_3),
        .DIV_4(DIV_4), .DIV_5(DIV_5), .DIV_6(DIV_6), .TMR_DIV(TMR_DIV), .LAT(LAT)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .use_tick(use_tick), .low_load(low_load), .high_load(high_load)
    );

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_q(scl_seen)
    );

    assign step     = use_tick ? tmr_tick : 1'b1;
    assign load_val = load_low ? low_load : high_load;

    scl_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .load(load_low | load_high),
        .load_val(load_val), .step(step), .done(phase_done)
    );

    scl_gen_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .scl_seen(scl_seen),
        .phase_done(phase_done), .scl_oe(scl_oe), .cnt_clear(cnt_clear),
        .load_low(load_low), .load_high(load_high)
    );
endmodule

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b0;
    logic [2:0] rate_sel = 3'd0;
    logic       tmr_tick = 1'b0;
    logic       ext_hold = 1'b0;
    logic       scl_oe;
    logic       bus_scl;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    localparam int EXP_HALF [0:6] = '{128, 112, 96, 80, 480, 60, 4800};

    always #10 clk = ~clk;

    assign bus_scl = !(scl_oe || ext_hold);

    scl_clock_gen dut_i (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .rate_sel(rate_sel),
        .tmr_tick(tmr_tick), .scl_i(bus_scl), .scl_oe(scl_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_oe(input logic v);
        int guard = 0;
        while (scl_oe !== v && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic run_len(input logic v, output int n);
        n = 0;
        while (scl_oe === v && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            repeat (9) @(negedge clk);
            tmr_tick = 1'b1;
            @(negedge clk);
            tmr_tick = 1'b0;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n, k, bad;
        // R1: line released during reset
        repeat (3) @(negedge clk);
        check(scl_oe == 1'b0, "R1", int'(scl_oe), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(scl_oe == 1'b0, "R1", int'(scl_oe), 0);

        // R2/R3: table walk over fixed codes
        for (int c = 0; c < 7; c++) begin
            master_en = 1'b0;
            rate_sel  = 3'(c);
            repeat (5) @(negedge clk);
            master_en = 1'b1;
            wait_oe(1'b1);
            run_len(1'b1, n);
            check(n == EXP_HALF[c], "R2", n, EXP_HALF[c]);
            run_len(1'b0, n);
            check(n == EXP_HALF[c], "R3", n, EXP_HALF[c]);
        end

        // R4: timer tick mode
        master_en = 1'b0;
        rate_sel  = 3'd7;
        repeat (5) @(negedge clk);
        master_en = 1'b1;
        wait_oe(1'b1);
        run_len(1'b1, n);
        check(n >= 31 && n <= 40, "R4", n, 35);
        run_len(1'b0, n);
        check(n >= 34 && n <= 43, "R4", n, 38);

        // R5: disable mid low phase
        master_en = 1'b0;
        rate_sel  = 3'd0;
        repeat (5) @(negedge clk);
        master_en = 1'b1;
        wait_oe(1'b1);
        repeat (10) @(negedge clk);
        master_en = 1'b0;
        @(negedge clk);
        check(scl_oe == 1'b0, "R5", int'(scl_oe), 0);
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (scl_oe) bad++;
        end
        check(bad == 0, "R5", bad, 0);

        // R6: stretching by an external holder
        rate_sel  = 3'd5;
        master_en = 1'b1;
        wait_oe(1'b1);
        ext_hold = 1'b1;
        run_len(1'b1, n);
        check(n == 60, "R6", n, 60);
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            if (scl_oe) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R6", bad, 0);
        ext_hold = 1'b0;
        n = 0;
        while (!scl_oe && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(n == 60, "R6", n, 60);

        // R7: another master pulls low during the high phase
        master_en = 1'b0;
        rate_sel  = 3'd0;
        repeat (5) @(negedge clk);
        master_en = 1'b1;
        wait_oe(1'b1);
        run_len(1'b1, n);
        repeat (20) @(negedge clk);
        check(scl_oe == 1'b0, "R7", int'(scl_oe), 0);
        ext_hold = 1'b1;
        k = 0;
        while (!scl_oe && k < 100) begin
            @(negedge clk);
            k++;
        end
        check(k == 3, "R7", k, 3);
        n = 0;
        while (scl_oe && n < 20000) begin
            n++;
            if (n == 3) ext_hold = 1'b0;
            @(negedge clk);
        end
        check(n == 128, "R7", n, 128);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule